// File: doc/BRIEF.md
# Sectored Direct-Mapped Data Cache with Critical-Word Refill

This block is a direct-mapped data cache. Each line has a single address tag, and the line is split into subblocks. Every subblock has its own valid flag and its own dirty flag, so a line can be partly present and partly modified. Reads return one word. Stores always write one whole subblock. A store can therefore mark its subblock valid and dirty without first reading it from the next level.

A read miss refills from a word-wide next-level port. The refill begins with the requested word and then wraps. The held read is answered in the cycle that word comes back. The rest of the refill continues in the background. While the refill runs, reads that hit are served, and this includes words of the line being filled once they have been written. When a line is replaced, only its dirty subblocks go back to memory.

The requester holds `req_i`, `we_i`, `addr_i` and `wdata_i` steady until `ack_o` is seen at a rising clock edge. The next-level port holds `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` steady until `mem_ack_i`. Each accepted transfer carries one word.

Top module: `sector_cache`

## Requirements
- R1: After reset every subblock is invalid and clean. The first read of any address therefore issues a next-level read, and no ack or memory request appears while idle.
- R2: Word address fields, from most significant: tag, index (3 bits), subblock (2 bits), word-in-subblock (1 bit). A read whose tag matches and whose subblock is valid is acked in the same cycle with the stored word, and it causes no next-level access.
- R3: A read whose tag matches, while its subblock is invalid and another subblock of the line is valid, fetches only that subblock's words. The fetch starts at the requested word and wraps within the subblock. The subblock is valid afterwards.
- R4: A read that misses the tag fetches all 8 words of the line. The first word fetched is the requested one, and fetch k uses line offset (requested offset + k) mod 8. The next-level request holds its address until it is accepted.
- R5: The held read is acked in the cycle its first fetched word is returned, with that word on `rdata_o`, before the other words arrive.
- R6: During a refill, reads that hit other lines are served at once, and so are reads of words of the filling line that have already arrived. A read of a word not yet fetched waits until that word is written.
- R7: A store writes its full subblock (word 0 in the low half of `wdata_i`) and sets that subblock valid and dirty with no next-level read. If the tag matches, or the victim line has no dirty subblock, it is acked in the same cycle.
- R8: Replacing a line writes back only its valid and dirty subblocks. Each goes back as a burst of consecutive word writes to the old tag's address: lowest dirty subblock first, words in ascending order. This happens before any refill read.
- R9: Subblocks that were only refilled stay clean. Replacing a line that has no dirty subblock issues no next-level write.
- R10: Stores stall while a refill or write-back is in progress and are acked only after it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request held until ack |
| we_i | input | 1 | 1 = full-subblock store, 0 = word read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | SUB_WORDS*DATA_W | Store data, word 0 in low bits |
| ack_o | output | 1 | Request completed this cycle |
| rdata_o | output | DATA_W | Read word, valid with ack_o on reads |
| mem_req_o | output | 1 | Next-level word transfer request |
| mem_we_o | output | 1 | 1 = write-back word, 0 = refill read |
| mem_addr_o | output | ADDR_W | Next-level word address |
| mem_wdata_o | output | DATA_W | Write-back word |
| mem_ack_i | input | 1 | Next-level transfer accepted |
| mem_rdata_i | input | DATA_W | Refill word, valid with mem_ack_i |

## Verification
The hardest state to reach is a read arriving mid-refill that targets a word of the filling line not yet fetched, while a hit to another line slips past it. The stimulus opens a whole-line miss with offset 0. Right after the early ack, it issues a hit to a different line and then a read of offset 7, the last word in wrap order. The memory model adds three cycles per word, so the refill is still running when both requests arrive. The stall is then shown by the count of refill reads already logged when each ack appears.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL
  } sc_state_e;
endpackage

// File: rtl/sc_meta_array.sv
module sc_meta_array #(
  parameter int SETS  = 8,
  parameter int SUBS  = 4,
  parameter int TAG_W = 10,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [TAG_W-1:0] tag_o,
  output logic [SUBS-1:0]  valid_o,
  output logic [SUBS-1:0]  dirty_o,
  input  logic [IDX_W-1:0] widx_i,
  input  logic             tag_we_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             v_we_i,
  input  logic [SUBS-1:0]  v_i,
  input  logic             d_we_i,
  input  logic [SUBS-1:0]  d_i
);
  logic [TAG_W-1:0] tag_q [SETS];
  logic [SUBS-1:0]  v_q   [SETS];
  logic [SUBS-1:0]  d_q   [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s] <= '0;
        v_q[s]   <= '0;
        d_q[s]   <= '0;
      end
    end else begin
      if (tag_we_i) tag_q[widx_i] <= tag_i;
      if (v_we_i)   v_q[widx_i]   <= v_i;
      if (d_we_i)   d_q[widx_i]   <= d_i;
    end
  end

  assign tag_o   = tag_q[ridx_i];
  assign valid_o = v_q[ridx_i];
  assign dirty_o = d_q[ridx_i];
endmodule

// File: rtl/sc_data_array.sv
module sc_data_array #(
  parameter int SETS      = 8,
  parameter int SUBS      = 4,
  parameter int SUB_WORDS = 2,
  parameter int DATA_W    = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int SUB_W = $clog2(SUBS),
  localparam int WW    = $clog2(SUB_WORDS),
  localparam int OFF_W = SUB_W + WW,
  localparam int DEPTH = SETS * SUBS * SUB_WORDS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [IDX_W-1:0]            ra_idx_i,
  input  logic [OFF_W-1:0]            ra_off_i,
  output logic [DATA_W-1:0]           ra_data_o,
  input  logic [IDX_W-1:0]            rb_idx_i,
  input  logic [OFF_W-1:0]            rb_off_i,
  output logic [DATA_W-1:0]           rb_data_o,
  input  logic                        fill_we_i,
  input  logic [IDX_W-1:0]            fill_idx_i,
  input  logic [OFF_W-1:0]            fill_off_i,
  input  logic [DATA_W-1:0]           fill_data_i,
  input  logic                        sub_we_i,
  input  logic [IDX_W-1:0]            sub_idx_i,
  input  logic [SUB_W-1:0]            sub_sel_i,
  input  logic [SUB_WORDS*DATA_W-1:0] sub_data_i
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (fill_we_i) mem_q[{fill_idx_i, fill_off_i}] <= fill_data_i;
    if (sub_we_i) begin
      for (int w = 0; w < SUB_WORDS; w++)
        mem_q[{sub_idx_i, sub_sel_i, WW'(w)}] <= sub_data_i[w*DATA_W +: DATA_W];
    end
  end

  assign ra_data_o = mem_q[{ra_idx_i, ra_off_i}];
  assign rb_data_o = mem_q[{rb_idx_i, rb_off_i}];

  // stores never land while a refill is writing
  AST_SINGLE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_we_i && sub_we_i)); // R10
endmodule

// File: rtl/sc_sub_pick.sv
module sc_sub_pick #(
  parameter int SUBS = 4,
  localparam int SUB_W = $clog2(SUBS)
) (
  input  logic [SUBS-1:0]  mask_i,
  output logic [SUB_W-1:0] sel_o
);
  // lowest set bit wins
  logic [SUB_W-1:0] chain [SUBS+1];
  assign chain[SUBS] = '0;
  for (genvar i = SUBS - 1; i >= 0; i--) begin : g_pick
    assign chain[i] = mask_i[i] ? SUB_W'(i) : chain[i+1];
  end
  assign sel_o = chain[0];
endmodule

// File: rtl/sector_cache.sv
module sector_cache
  import sc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int SETS      = 8,
  parameter int SUBS      = 4,
  parameter int SUB_WORDS = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [SUB_WORDS*DATA_W-1:0] wdata_i,
  output logic                        ack_o,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        mem_req_o,
  output logic                        mem_we_o,
  output logic [ADDR_W-1:0]           mem_addr_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  input  logic                        mem_ack_i,
  input  logic [DATA_W-1:0]           mem_rdata_i
);
  localparam int IDX_W      = $clog2(SETS);
  localparam int SUB_W      = $clog2(SUBS);
  localparam int WW         = $clog2(SUB_WORDS);
  localparam int OFF_W      = SUB_W + WW;
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_WORDS = SUBS * SUB_WORDS;

  sc_state_e state_q;
  logic              pend_q, op_we_q, fill_line_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [TAG_W-1:0]  victim_tag_q;
  logic [SUBS-1:0]   wb_mask_q, fill_v_q;
  logic [WW-1:0]     wb_word_q;
  logic [OFF_W-1:0]  fill_cnt_q;
  logic [LINE_WORDS-1:0] filled_q;

  // request and held-miss field split
  logic [OFF_W-1:0] a_off, r_off, fill_off;
  logic [SUB_W-1:0] a_sub, r_sub, wb_sub;
  logic [IDX_W-1:0] a_idx, r_idx;
  logic [TAG_W-1:0] a_tag, r_tag, tag_r;
  logic [WW-1:0]    r_w, fill_w;
  assign a_off = addr_i[OFF_W-1:0];
  assign a_sub = addr_i[OFF_W-1:WW];
  assign a_idx = addr_i[OFF_W +: IDX_W];
  assign a_tag = addr_i[ADDR_W-1 -: TAG_W];
  assign r_off = req_addr_q[OFF_W-1:0];
  assign r_sub = req_addr_q[OFF_W-1:WW];
  assign r_w   = req_addr_q[WW-1:0];
  assign r_idx = req_addr_q[OFF_W +: IDX_W];
  assign r_tag = req_addr_q[ADDR_W-1 -: TAG_W];

  logic [SUBS-1:0] v_r, d_r, vd_r, sub_oh, wb_oh, fill_mask;
  logic            m_tag_we, m_v_we, m_d_we;
  logic [IDX_W-1:0] m_widx;
  logic [TAG_W-1:0] m_tag;
  logic [SUBS-1:0]  m_v, m_d;
  logic [DATA_W-1:0] hit_data;

  sc_meta_array #(.SETS(SETS), .SUBS(SUBS), .TAG_W(TAG_W)) u_meta (
    .clk_i, .rst_ni, .ridx_i(a_idx), .tag_o(tag_r), .valid_o(v_r), .dirty_o(d_r),
    .widx_i(m_widx), .tag_we_i(m_tag_we), .tag_i(m_tag),
    .v_we_i(m_v_we), .v_i(m_v), .d_we_i(m_d_we), .d_i(m_d));

  sc_sub_pick #(.SUBS(SUBS)) u_pick (.mask_i(wb_mask_q), .sel_o(wb_sub));

  assign vd_r      = v_r & d_r;
  assign sub_oh    = SUBS'(1) << a_sub;
  assign wb_oh     = SUBS'(1) << wb_sub;
  assign fill_mask = fill_line_q ? '1 : (SUBS'(1) << r_sub);
  assign fill_w    = r_w + fill_cnt_q[WW-1:0];
  assign fill_off  = fill_line_q ? r_off + fill_cnt_q : {r_sub, fill_w};

  logic tag_hit, fill_match, word_hit, rd_hit, rd_miss, st_ok, st_hit, st_clean, st_wb;
  logic fill_ack, fill_last, wb_burst_end, wb_last_sub;
  assign tag_hit    = (tag_r == a_tag) && (|v_r);
  assign fill_match = (state_q == ST_FILL) && (a_idx == r_idx) && (a_tag == r_tag);
  assign word_hit   = ((tag_r == a_tag) && v_r[a_sub]) || (fill_match && filled_q[a_off]);
  assign rd_hit     = req_i && !we_i && !pend_q && (state_q != ST_WB) && word_hit;
  assign rd_miss    = req_i && !we_i && (state_q == ST_IDLE) && !word_hit;
  assign st_ok      = req_i && we_i && (state_q == ST_IDLE);
  assign st_hit     = st_ok && tag_hit;
  assign st_clean   = st_ok && !tag_hit && !(|vd_r);
  assign st_wb      = st_ok && !tag_hit && (|vd_r);
  assign fill_last  = fill_cnt_q == (fill_line_q ? OFF_W'(LINE_WORDS-1) : OFF_W'(SUB_WORDS-1));
  assign fill_ack   = (state_q == ST_FILL) && pend_q && mem_ack_i && (fill_cnt_q == '0);
  assign wb_last_sub  = (wb_mask_q & ~wb_oh) == '0;
  assign wb_burst_end = (state_q == ST_WB) && mem_ack_i && (wb_word_q == WW'(SUB_WORDS-1)) && wb_last_sub;

  assign ack_o       = rd_hit || st_hit || st_clean || fill_ack;
  assign rdata_o     = fill_ack ? mem_rdata_i : hit_data;
  assign mem_req_o   = state_q != ST_IDLE;
  assign mem_we_o    = state_q == ST_WB;
  assign mem_addr_o  = (state_q == ST_WB) ? {victim_tag_q, r_idx, wb_sub, wb_word_q}
                                          : {r_tag, r_idx, fill_off};

  sc_data_array #(.SETS(SETS), .SUBS(SUBS), .SUB_WORDS(SUB_WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i, .rst_ni,
    .ra_idx_i(a_idx), .ra_off_i(a_off), .ra_data_o(hit_data),
    .rb_idx_i(r_idx), .rb_off_i({wb_sub, wb_word_q}), .rb_data_o(mem_wdata_o),
    .fill_we_i((state_q == ST_FILL) && mem_ack_i), .fill_idx_i(r_idx),
    .fill_off_i(fill_off), .fill_data_i(mem_rdata_i),
    .sub_we_i(st_hit || st_clean), .sub_idx_i(a_idx), .sub_sel_i(a_sub), .sub_data_i(wdata_i));

  always_comb begin
    m_widx   = a_idx;
    m_tag    = a_tag;
    m_v      = v_r | sub_oh;
    m_d      = d_r | sub_oh;
    m_tag_we = 1'b0;
    m_v_we   = 1'b0;
    m_d_we   = 1'b0;
    if (st_hit) begin
      m_v_we = 1'b1;
      m_d_we = 1'b1;
    end else if (st_clean) begin
      {m_tag_we, m_v_we, m_d_we} = '1;
      m_v = sub_oh;
      m_d = sub_oh;
    end else if (rd_miss && !tag_hit && !(|vd_r)) begin
      {m_tag_we, m_v_we, m_d_we} = '1;
      m_v = '0;
      m_d = '0;
    end else if (wb_burst_end) begin
      {m_tag_we, m_v_we, m_d_we} = '1;
      m_widx = r_idx;
      m_tag  = r_tag;
      m_v    = '0;
      m_d    = '0;
    end else if ((state_q == ST_FILL) && mem_ack_i && fill_last) begin
      m_widx = r_idx;
      m_v_we = 1'b1;
      m_v    = fill_v_q | fill_mask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      pend_q       <= 1'b0;
      op_we_q      <= 1'b0;
      fill_line_q  <= 1'b0;
      req_addr_q   <= '0;
      victim_tag_q <= '0;
      wb_mask_q    <= '0;
      fill_v_q     <= '0;
      wb_word_q    <= '0;
      fill_cnt_q   <= '0;
      filled_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (rd_miss || st_wb) begin
            req_addr_q <= addr_i;
            pend_q     <= 1'b1;
            op_we_q    <= we_i;
            fill_cnt_q <= '0;
            filled_q   <= '0;
            wb_word_q  <= '0;
            if (rd_miss && tag_hit) begin
              fill_line_q <= 1'b0;
              fill_v_q    <= v_r;
              state_q     <= ST_FILL;
            end else if (|vd_r) begin
              victim_tag_q <= tag_r;
              wb_mask_q    <= vd_r;
              fill_line_q  <= 1'b1;
              state_q      <= ST_WB;
            end else begin
              fill_line_q <= 1'b1;
              fill_v_q    <= '0;
              state_q     <= ST_FILL;
            end
          end
        end
        ST_WB: begin
          if (mem_ack_i) begin
            if (wb_word_q == WW'(SUB_WORDS-1)) begin
              wb_word_q <= '0;
              wb_mask_q <= wb_mask_q & ~wb_oh;
              if (wb_last_sub) begin
                fill_v_q <= '0;
                if (op_we_q) begin
                  pend_q  <= 1'b0;
                  state_q <= ST_IDLE;
                end else begin
                  state_q <= ST_FILL;
                end
              end
            end else begin
              wb_word_q <= wb_word_q + 1'b1;
            end
          end
        end
        ST_FILL: begin
          if (mem_ack_i) begin
            filled_q[fill_off] <= 1'b1;
            if (fill_ack) pend_q <= 1'b0;
            if (fill_last) begin
              fill_cnt_q <= '0;
              state_q    <= ST_IDLE;
            end else begin
              fill_cnt_q <= fill_cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // requester holds addr_i, so the lookup still shows the victim line
  AST_WB_ONLY_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (v_r[wb_sub] && d_r[wb_sub])); // R8
  AST_CRIT_WORD_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_ack |-> (mem_addr_o == addr_i) && !mem_we_o); // R5
  AST_ONE_ACK_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_hit, st_hit || st_clean, fill_ack})); // R6
  AST_STORE_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && we_i) |-> !mem_req_o); // R7
  AST_MEM_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o)); // R4
endmodule

// File: tb/sector_cache_test.sv
`timescale 1ns/1ps
module sector_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [63:0] wdata = '0;
  logic        ack;
  logic [31:0] rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;

  int n_chk = 0, n_fail = 0;
  logic [15:0] lg_addr [512];
  logic        lg_we   [512];
  logic [31:0] lg_data [512];
  int lg_n = 0, wc = 0;

  always #5 clk = ~clk;

  sector_cache uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ack_o(ack), .rdata_o(rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata));

  function automatic logic [31:0] mem_f(input logic [15:0] a);
    return 32'h5A00_0000 | {16'h0, a};
  endfunction

  // next-level model: accepts each word on its second waiting cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; wc = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; wc = 0;
    end else if (mem_req) begin
      wc++;
      if (wc == 2) begin
        mem_ack   = 1'b1;
        mem_rdata = mem_f(mem_addr);
        if (lg_n < 512) begin
          lg_addr[lg_n] = mem_addr; lg_we[lg_n] = mem_we; lg_data[lg_n] = mem_wdata;
        end
        lg_n++;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic cpu(input logic w, input logic [15:0] a, input logic [63:0] wd,
                     output logic [31:0] rd, output int cyc, output int nl);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = wd; cyc = 0;
    #1;
    while (!ack && cyc < 1000) begin
      @(negedge clk); #1; cyc++;
    end
    rd = rdata; nl = lg_n;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (mem_req) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  logic [31:0] rd;
  int cyc, nl, n0;

  task automatic t_reset();
    #1;
    chk("R1 ack idle", 32'(ack), 0);
    chk("R1 mem idle", 32'(mem_req), 0);
  endtask

  task automatic t_line_miss();
    n0 = lg_n;
    cpu(1'b0, 16'h0105, '0, rd, cyc, nl);
    chk("R1 first read fetches", 32'(nl - n0), 1);
    chk("R5 critical data", rd, mem_f(16'h0105));
    wait_idle();
    chk("R4 line word count", 32'(lg_n - n0), 8);
    for (int k = 0; k < 8; k++) begin
      chk("R4 wrap order", 32'(lg_addr[n0+k]), 32'(16'h0100 + ((5 + k) % 8)));
      chk("R4 read only", 32'(lg_we[n0+k]), 0);
    end
  endtask

  task automatic t_hit();
    n0 = lg_n;
    cpu(1'b0, 16'h0100, '0, rd, cyc, nl);
    chk("R2 hit latency", 32'(cyc), 0);
    chk("R2 hit data", rd, mem_f(16'h0100));
    cpu(1'b0, 16'h0107, '0, rd, cyc, nl);
    chk("R2 hit data", rd, mem_f(16'h0107));
    chk("R2 no mem access", 32'(lg_n - n0), 0);
  endtask

  task automatic t_hit_under_fill();
    n0 = lg_n;
    cpu(1'b0, 16'h0108, '0, rd, cyc, nl);
    chk("R5 early ack", 32'(nl - n0), 1);
    cpu(1'b0, 16'h0102, '0, rd, cyc, nl);
    chk("R6 other line served mid-fill", 32'((nl - n0) < 8), 1);
    chk("R6 other line data", rd, mem_f(16'h0102));
    cpu(1'b0, 16'h010F, '0, rd, cyc, nl);
    chk("R6 waits for its word", 32'(nl - n0), 8);
    chk("R6 late word data", rd, mem_f(16'h010F));
    wait_idle();
  endtask

  task automatic t_store_hit();
    n0 = lg_n;
    cpu(1'b1, 16'h0102, {32'hD000_0003, 32'hD000_0002}, rd, cyc, nl);
    chk("R7 store ack latency", 32'(cyc), 0);
    repeat (3) @(negedge clk);
    chk("R7 store no mem", 32'(lg_n - n0), 0);
    cpu(1'b0, 16'h0103, '0, rd, cyc, nl);
    chk("R7 stored word1", rd, 32'hD000_0003);
    cpu(1'b0, 16'h0102, '0, rd, cyc, nl);
    chk("R7 stored word0", rd, 32'hD000_0002);
  endtask

  task automatic t_store_alloc_sub_fill();
    n0 = lg_n;
    cpu(1'b1, 16'h0114, {32'hD000_0015, 32'hD000_0014}, rd, cyc, nl);
    chk("R7 alloc store latency", 32'(cyc), 0);
    cpu(1'b0, 16'h0115, '0, rd, cyc, nl);
    chk("R7 alloc store data", rd, 32'hD000_0015);
    chk("R7 alloc no mem", 32'(lg_n - n0), 0);
    n0 = lg_n;
    cpu(1'b0, 16'h0111, '0, rd, cyc, nl);
    chk("R3 sub miss critical", rd, mem_f(16'h0111));
    wait_idle();
    chk("R3 only subblock fetched", 32'(lg_n - n0), 2);
    chk("R3 first addr", 32'(lg_addr[n0]), 32'h0111);
    chk("R3 wrap addr", 32'(lg_addr[n0+1]), 32'h0110);
    cpu(1'b0, 16'h0110, '0, rd, cyc, nl);
    chk("R3 sub valid after fill", 32'(cyc), 0);
    chk("R3 sub data", rd, mem_f(16'h0110));
  endtask

  task automatic t_evict_dirty_read();
    n0 = lg_n;
    cpu(1'b0, 16'h0205, '0, rd, cyc, nl);
    chk("R8 wb before refill", 32'(nl - n0), 3);
    chk("R8 refill data", rd, mem_f(16'h0205));
    wait_idle();
    chk("R8 total transfers", 32'(lg_n - n0), 10);
    chk("R8 wb0 write", 32'(lg_we[n0]), 1);
    chk("R8 wb0 addr", 32'(lg_addr[n0]), 32'h0102);
    chk("R8 wb0 data", lg_data[n0], 32'hD000_0002);
    chk("R8 wb1 addr", 32'(lg_addr[n0+1]), 32'h0103);
    chk("R8 wb1 data", lg_data[n0+1], 32'hD000_0003);
    chk("R8 refill start", 32'(lg_addr[n0+2]), 32'h0205);
    chk("R8 refill read", 32'(lg_we[n0+2]), 0);
  endtask

  task automatic t_evict_for_store();
    n0 = lg_n;
    cpu(1'b1, 16'h0310, {32'hD000_0031, 32'hD000_0030}, rd, cyc, nl);
    chk("R8 store wb count", 32'(nl - n0), 2);
    chk("R8 wb addr", 32'(lg_addr[n0]), 32'h0114);
    chk("R8 wb data", lg_data[n0], 32'hD000_0014);
    chk("R8 wb addr", 32'(lg_addr[n0+1]), 32'h0115);
    chk("R8 wb data", lg_data[n0+1], 32'hD000_0015);
    wait_idle();
    chk("R9 clean sub not written, R7 no read", 32'(lg_n - n0), 2);
    cpu(1'b0, 16'h0311, '0, rd, cyc, nl);
    chk("R7 store after wb data", rd, 32'hD000_0031);
  endtask

  task automatic t_clean_evict();
    n0 = lg_n;
    cpu(1'b0, 16'h0308, '0, rd, cyc, nl);
    chk("R9 no wb for clean line", 32'(nl - n0), 1);
    chk("R9 first is read", 32'(lg_we[n0]), 0);
    wait_idle();
    chk("R9 only reads", 32'(lg_n - n0), 8);
  endtask

  task automatic t_store_stall();
    n0 = lg_n;
    cpu(1'b0, 16'h0018, '0, rd, cyc, nl);
    chk("R5 early ack", 32'(nl - n0), 1);
    cpu(1'b1, 16'h0206, {32'hD000_0207, 32'hD000_0206}, rd, cyc, nl);
    chk("R10 store waits for fill", 32'(nl - n0), 8);
    cpu(1'b0, 16'h0207, '0, rd, cyc, nl);
    chk("R10 stalled store data", rd, 32'hD000_0207);
  endtask

  initial begin
    #1_500_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_line_miss();
    t_hit();
    t_hit_under_fill();
    t_store_hit();
    t_store_alloc_sub_fill();
    t_evict_dirty_read();
    t_evict_for_store();
    t_clean_evict();
    t_store_stall();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule